// File: doc/BRIEF.md
# Shared Window Comparator Rail Scanner

This controller lets one pair of comparators watch several supply rails. It visits the enabled rails one at a time. For each rail it drives the external analog multiplexer select and loads that rail's low and high limit codes into the two external DAC code registers. It then waits a programmable number of settling cycles and samples the two comparator results. When the scan of that rail is done it moves on to the next enabled rail, and it wraps round to the first one after the last.

Each rail has its own out-of-window counter, which advances only when that rail is sampled. A rail is declared failed only when it has stayed out of window for more consecutive samples than the programmed filter length. Failure sets a sticky per-rail fail flag and a sticky per-rail cause flag (low or high). These flags drive a single interrupt line. A host clears the flags of a rail with a one-cycle pulse on that rail's clear line. Limit codes live in a small table that the host writes through a simple write port.

Top module: `wcs_scanner`

## Requirements
- R1: After reset, `mux_sel_o`, `dac_uv_o`, `dac_ov_o`, every fail and cause flag, and `irq_o` are all 0.
- R2: Rails whose bit in `rail_en_i` is 1 are selected in ascending index order and the order wraps round. Rails with a 0 bit are skipped. The first selection after reset is the lowest enabled index. When no rail is enabled, the select and DAC outputs hold their values.
- R3: In the cycle that `mux_sel_o` takes a rail index, `dac_uv_o` and `dac_ov_o` take that rail's low and high table entries.
- R4: Each visit lasts `settle_i`+2 cycles. The comparators are sampled on the rising edge `settle_i`+1 edges after the select edge, and the next rail is selected on the edge after that.
- R5: A rail fails on its (`filt_len_i`+1)-th consecutive out-of-window sample. A sample of that rail with both comparators at 0 resets its count.
- R6: `uv_cmp_i`=1 means the rail is below its low limit, and `ov_cmp_i`=1 means it is above its high limit. The cause flags record which of the two was 1 on the sample that tripped, and a cause flag is never set without the fail flag.
- R7: Fail and cause flags are sticky. They are cleared only by `clr_i[i]`=1 for that rail, and they do not change the flags of other rails.
- R8: `irq_o` is 1 exactly when at least one fail flag is set.
- R9: A write with `lim_we_i`=1 stores `lim_uv_i`/`lim_ov_i` at entry `lim_idx_i`. The new codes reach the DAC outputs at the next selection of that rail, not before.
- R10: A fail flag rises only for the rail currently on `mux_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail_en_i | input | N_RAILS | Per-rail scan enable |
| settle_i | input | SETTLE_W | Settling cycles before sampling |
| filt_len_i | input | FILT_W | Glitch filter length |
| lim_we_i | input | 1 | Limit table write strobe |
| lim_idx_i | input | IDX_W | Limit table write index |
| lim_uv_i | input | CODE_W | Low limit code to write |
| lim_ov_i | input | CODE_W | High limit code to write |
| uv_cmp_i | input | 1 | Comparator result: rail below low limit |
| ov_cmp_i | input | 1 | Comparator result: rail above high limit |
| clr_i | input | N_RAILS | Per-rail flag clear |
| mux_sel_o | output | IDX_W | Analog multiplexer select |
| dac_uv_o | output | CODE_W | Low limit DAC code |
| dac_ov_o | output | CODE_W | High limit DAC code |
| fail_o | output | N_RAILS | Sticky per-rail fail flags |
| uv_cause_o | output | N_RAILS | Sticky low-limit cause flags |
| ov_cause_o | output | N_RAILS | Sticky high-limit cause flags |
| irq_o | output | 1 | Fault interrupt |

## Verification
The select and both DAC codes change on one edge, and that edge repeats every `settle_i`+2 cycles. The scoreboard monitor works out each select edge from that period and checks the popped item just after the edge. On the sample edge `settle_i`+1 cycles later it confirms that the select has not moved yet. A fail flag appears just after the sample edge of the tripping visit and not one cycle earlier. The bench places its comparator patterns on known visit numbers, then checks one cycle before and one cycle after that edge. Clears and limit writes take effect on the next edge, and the DAC code for a rewritten entry is checked both before and at that rail's next select edge.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic {
    ST_PICK,
    ST_WAIT
  } scan_st_e;
endpackage

// File: rtl/wcs_limit_table.sv
module wcs_limit_table #(
  parameter int N_RAILS = 4,
  parameter int CODE_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [CODE_W-1:0] wuv_i,
  input  logic [CODE_W-1:0] wov_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [CODE_W-1:0] ruv_o,
  output logic [CODE_W-1:0] rov_o
);
  logic [CODE_W-1:0] uv_mem [N_RAILS];
  logic [CODE_W-1:0] ov_mem [N_RAILS];

  // storage only, no reset needed
  always_ff @(posedge clk_i) begin
    if (we_i && (int'(widx_i) < N_RAILS)) begin
      uv_mem[widx_i] <= wuv_i;
      ov_mem[widx_i] <= wov_i;
    end
  end

  assign ruv_o = uv_mem[ridx_i];
  assign rov_o = ov_mem[ridx_i];
endmodule

// File: rtl/wcs_rail_pick.sv
module wcs_rail_pick #(
  parameter int N_RAILS = 4,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0]   cur_i,
  input  logic [N_RAILS-1:0] en_i,
  output logic [IDX_W-1:0]   nxt_o,
  output logic               any_o
);
  // scan offsets downward so the nearest enabled rail after cur_i wins
  always_comb begin
    nxt_o = cur_i;
    any_o = 1'b0;
    for (int k = N_RAILS; k >= 1; k--) begin
      int idx;
      idx = (int'(cur_i) + k) % N_RAILS;
      if (en_i[idx]) begin
        nxt_o = IDX_W'(idx);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wcs_glitch_filter.sv
module wcs_glitch_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  logic              uv_i,
  input  logic              ov_i,
  input  logic [FILT_W-1:0] len_i,
  input  logic              clr_i,
  output logic              fail_o,
  output logic              uv_o,
  output logic              ov_o
);
  logic [FILT_W-1:0] cnt_q;
  logic              out_win, full, trip;

  assign out_win = uv_i | ov_i;
  assign full    = cnt_q >= len_i;
  assign trip    = smp_i & out_win & full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fail_o <= 1'b0;
      uv_o   <= 1'b0;
      ov_o   <= 1'b0;
    end else begin
      if (smp_i) begin
        if (!out_win)  cnt_q <= '0;
        else if (!full) cnt_q <= cnt_q + FILT_W'(1);
      end
      fail_o <= (fail_o & ~clr_i) | trip;
      uv_o   <= (uv_o & ~clr_i) | (trip & uv_i);
      ov_o   <= (ov_o & ~clr_i) | (trip & ov_i);
    end
  end
endmodule

// File: rtl/wcs_scanner.sv
module wcs_scanner
  import wcs_pkg::*;
#(
  parameter int N_RAILS  = 4,
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 4,
  parameter int FILT_W   = 4,
  localparam int IDX_W   = (N_RAILS > 1) ? $clog2(N_RAILS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_RAILS-1:0]  rail_en_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [FILT_W-1:0]   filt_len_i,
  input  logic                lim_we_i,
  input  logic [IDX_W-1:0]    lim_idx_i,
  input  logic [CODE_W-1:0]   lim_uv_i,
  input  logic [CODE_W-1:0]   lim_ov_i,
  input  logic                uv_cmp_i,
  input  logic                ov_cmp_i,
  input  logic [N_RAILS-1:0]  clr_i,
  output logic [IDX_W-1:0]    mux_sel_o,
  output logic [CODE_W-1:0]   dac_uv_o,
  output logic [CODE_W-1:0]   dac_ov_o,
  output logic [N_RAILS-1:0]  fail_o,
  output logic [N_RAILS-1:0]  uv_cause_o,
  output logic [N_RAILS-1:0]  ov_cause_o,
  output logic                irq_o
);
  scan_st_e            st_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [IDX_W-1:0]    cur_q, nxt;
  logic                any_en, smp;
  logic [CODE_W-1:0]   tbl_uv, tbl_ov;

  wcs_limit_table #(.N_RAILS(N_RAILS), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_tbl (
    .clk_i  (clk_i),
    .we_i   (lim_we_i),
    .widx_i (lim_idx_i),
    .wuv_i  (lim_uv_i),
    .wov_i  (lim_ov_i),
    .ridx_i (nxt),
    .ruv_o  (tbl_uv),
    .rov_o  (tbl_ov)
  );

  wcs_rail_pick #(.N_RAILS(N_RAILS), .IDX_W(IDX_W)) u_pick (
    .cur_i (cur_q),
    .en_i  (rail_en_i),
    .nxt_o (nxt),
    .any_o (any_en)
  );

  assign smp = (st_q == ST_WAIT) && (cnt_q >= settle_i);

  // cur_q starts at the last rail so the first pick lands on the lowest enabled index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_PICK;
      cnt_q     <= '0;
      cur_q     <= IDX_W'(N_RAILS - 1);
      mux_sel_o <= '0;
      dac_uv_o  <= '0;
      dac_ov_o  <= '0;
    end else begin
      unique case (st_q)
        ST_PICK: if (any_en) begin
          cur_q     <= nxt;
          mux_sel_o <= nxt;
          dac_uv_o  <= tbl_uv;
          dac_ov_o  <= tbl_ov;
          cnt_q     <= '0;
          st_q      <= ST_WAIT;
        end
        ST_WAIT: if (smp) st_q <= ST_PICK;
                 else     cnt_q <= cnt_q + SETTLE_W'(1);
        default: st_q <= ST_PICK;
      endcase
    end
  end

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    wcs_glitch_filter #(.FILT_W(FILT_W)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp && (cur_q == IDX_W'(i))),
      .uv_i   (uv_cmp_i),
      .ov_i   (ov_cmp_i),
      .len_i  (filt_len_i),
      .clr_i  (clr_i[i]),
      .fail_o (fail_o[i]),
      .uv_o   (uv_cause_o[i]),
      .ov_o   (ov_cause_o[i])
    );
  end

  assign irq_o = |fail_o;
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
  parameter int N_RAILS = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_RAILS-1:0] rail_en_i,
  input logic [N_RAILS-1:0] clr_i,
  input logic [IDX_W-1:0]   mux_sel_o,
  input logic [N_RAILS-1:0] fail_o,
  input logic [N_RAILS-1:0] uv_cause_o,
  input logic [N_RAILS-1:0] ov_cause_o
);
  // R2
  sel_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mux_sel_o) |-> ((($past(rail_en_i) >> mux_sel_o) & N_RAILS'(1)) != '0));

  for (genvar i = 0; i < N_RAILS; i++) begin : g_chk
    // R7
    sticky_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fail_o[i] && !clr_i[i]) |=> fail_o[i]);
    // R6
    cause_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uv_cause_o[i] || ov_cause_o[i]) |-> fail_o[i]);
    // R10
    fail_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fail_o[i]) |-> (mux_sel_o == IDX_W'(i)));
  end
endmodule

bind wcs_scanner wcs_checker #(.N_RAILS(N_RAILS), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/wcs_scanner_test.sv
module wcs_scanner_test;
  localparam int N = 4, CW = 8, SW = 4, FW = 4, IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]  rail_en = '0;
  logic [SW-1:0] settle = '0;
  logic [FW-1:0] flen = '0;
  logic          lim_we = 1'b0;
  logic [IW-1:0] lim_idx = '0;
  logic [CW-1:0] lim_uv = '0, lim_ov = '0;
  logic [N-1:0]  clr = '0;
  logic [N-1:0]  bad_uv = '0, bad_ov = '0;
  logic          uv_cmp, ov_cmp;
  logic [IW-1:0] mux_sel;
  logic [CW-1:0] dac_uv, dac_ov;
  logic [N-1:0]  fail, uv_cause, ov_cause;
  logic          irq;

  // comparator model: result follows the selected rail
  assign uv_cmp = bad_uv[mux_sel];
  assign ov_cmp = bad_ov[mux_sel];

  wcs_scanner #(.N_RAILS(N), .CODE_W(CW), .SETTLE_W(SW), .FILT_W(FW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rail_en_i(rail_en), .settle_i(settle),
    .filt_len_i(flen), .lim_we_i(lim_we), .lim_idx_i(lim_idx),
    .lim_uv_i(lim_uv), .lim_ov_i(lim_ov), .uv_cmp_i(uv_cmp), .ov_cmp_i(ov_cmp),
    .clr_i(clr), .mux_sel_o(mux_sel), .dac_uv_o(dac_uv), .dac_ov_o(dac_ov),
    .fail_o(fail), .uv_cause_o(uv_cause), .ov_cause_o(ov_cause), .irq_o(irq)
  );

  int total = 0, bad = 0, t = 0;
  int exp_uv [N];
  int exp_ov [N];
  typedef struct { int rail; int uv; int ov; } exp_t;
  exp_t q [$];

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, t);
    end
  endtask

  task automatic upto(int e);
    while (t < e) begin
      @(posedge clk);
      t++;
    end
    #1;
  endtask

  task automatic hold_reset(logic [N-1:0] en, int s, int l);
    @(negedge clk);
    rst_n = 1'b0;
    rail_en = en; settle = SW'(s); flen = FW'(l);
    bad_uv = '0; bad_ov = '0; clr = '0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t = 0;
    #1;
  endtask

  task automatic wr(int idx, int uv, int ov);
    @(negedge clk);
    lim_we = 1'b1; lim_idx = IW'(idx); lim_uv = CW'(uv); lim_ov = CW'(ov);
    exp_uv[idx] = uv; exp_ov[idx] = ov;
    @(negedge clk);
    lim_we = 1'b0;
  endtask

  // driver: expected selection items from the bench's own table copy
  task automatic push(int r);
    q.push_back('{r, exp_uv[r], exp_ov[r]});
  endtask

  // monitor: select edges fall every settle+2 cycles starting at edge 1
  task automatic monitor(int s);
    int k = 0;
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      int sel = 1 + k * (s + 2);
      upto(sel);
      chk("R2 select order", int'(mux_sel), e.rail);
      chk("R3 low dac code", int'(dac_uv), e.uv);
      chk("R3 high dac code", int'(dac_ov), e.ov);
      upto(sel + s + 1);
      chk("R4 select held through sample edge", int'(mux_sel), e.rail);
      k++;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // phase A: scoreboard scan with a gap in the enable mask
    hold_reset(4'b1011, 2, 0);
    wr(0, 10, 200); wr(1, 20, 210); wr(2, 30, 220); wr(3, 40, 230);
    release_reset();
    chk("R1 mux after reset", int'(mux_sel), 0);
    chk("R1 dac low after reset", int'(dac_uv), 0);
    chk("R1 dac high after reset", int'(dac_ov), 0);
    chk("R1 fail after reset", int'(fail), 0);
    chk("R1 causes after reset", int'(uv_cause | ov_cause), 0);
    chk("R1 irq after reset", int'(irq), 0);
    push(0); push(1); push(3); push(0); push(1); push(3);
    monitor(2);

    // phase A2: all rails, zero settle
    hold_reset(4'b1111, 0, 0);
    release_reset();
    push(0); push(1); push(2); push(3); push(0); push(1);
    monitor(0);

    // phase B: table rewrite and all-disabled hold
    hold_reset(4'b0100, 2, 0);
    release_reset();
    upto(1);
    chk("R2 single rail selected", int'(mux_sel), 2);
    chk("R3 rail 2 low code", int'(dac_uv), 30);
    upto(6);
    lim_we = 1'b1; lim_idx = 2'd2; lim_uv = 8'd77; lim_ov = 8'd188;
    upto(7);
    lim_we = 1'b0; exp_uv[2] = 77; exp_ov[2] = 188;
    upto(8);
    chk("R9 old code until reselect", int'(dac_uv), 30);
    upto(9);
    chk("R9 new low code at reselect", int'(dac_uv), 77);
    chk("R9 new high code at reselect", int'(dac_ov), 188);
    rail_en = '0;
    upto(40);
    chk("R2 select held with none enabled", int'(mux_sel), 2);
    chk("R2 dac held with none enabled", int'(dac_ov), 188);

    // phase C: glitch filter, causes, clear, interrupt (settle 2, length 2)
    hold_reset(4'b1111, 2, 2);
    release_reset();
    bad_ov[0] = 1'b1;
    bad_uv[3] = 1'b1;
    upto(32); bad_uv[3] = 1'b0;
    upto(35);
    chk("R5 rail 0 not failed before third sample", int'(fail[0]), 0);
    chk("R8 irq low before any fail", int'(irq), 0);
    upto(36);
    chk("R5 rail 0 fails on third sample", int'(fail[0]), 1);
    chk("R6 rail 0 high cause", int'(ov_cause[0]), 1);
    chk("R6 rail 0 no low cause", int'(uv_cause[0]), 0);
    chk("R8 irq on fail", int'(irq), 1);
    upto(48); bad_uv[3] = 1'b1;
    upto(80); bad_uv[3] = 1'b0;
    upto(100);
    chk("R5 in-window sample resets count", int'(fail[3]), 0);
    bad_uv[3] = 1'b1;
    bad_ov[0] = 1'b0;
    upto(140);
    chk("R7 fail sticky after fault gone", int'(fail[0]), 1);
    upto(143);
    chk("R5 rail 3 not failed before third sample", int'(fail[3]), 0);
    upto(144);
    chk("R5 rail 3 fails on third sample", int'(fail[3]), 1);
    chk("R6 rail 3 low cause", int'(uv_cause[3]), 1);
    chk("R6 rail 3 no high cause", int'(ov_cause[3]), 0);
    upto(150);
    bad_uv[3] = 1'b0;
    clr = 4'b0001;
    upto(151);
    clr = '0;
    chk("R7 clear drops rail 0 fail", int'(fail[0]), 0);
    chk("R7 clear drops rail 0 cause", int'(ov_cause[0]), 0);
    chk("R7 clear leaves rail 3", int'(fail[3]), 1);
    chk("R8 irq held by rail 3", int'(irq), 1);
    upto(160);
    clr = 4'b1000;
    upto(161);
    clr = '0;
    chk("R7 clear drops rail 3 fail", int'(fail[3]), 0);
    chk("R8 irq low with no fail", int'(irq), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule